// File: doc/BRIEF.md
# Four-Channel PWM Register Controller

This block is the register front end of a four-channel pulse-width modulator. It decodes accesses from a simple synchronous bus and keeps each channel's configuration: mode, duty, period and a staged update word. It drives a run-enable level to every channel and gathers the channels' period-start events into an interrupt status word. The waveform generators live in a separate channel block. That block receives the enables and register values from this controller and reports two things back: which channels are actually running, and when each channel starts a new period.

Software starts channels by writing ones to a set register and stops them by writing ones to a clear register. Zero bits in either write leave the other channels alone. The running-status word comes straight from the channel block, so a stop becomes visible only once the generator has really halted. The interrupt status word is sticky and is cleared as a whole by reading it. An event that lands in the same cycle as that read is kept for the next read.

The request side is a valid/ready pair. Ready is always high, so the controller never applies back-pressure: every cycle with valid high is one accepted access. A read returns its data on the response pins exactly one cycle after it is accepted. The response has no ready, so the requester must take it in that cycle.

Top module: `pwmc_top`

## Requirements
- R1: After reset, all run enables, start pulses, update strobes, the interrupt status word, every channel register and the response pins are zero.
- R2: A write to byte offset 0x04 sets the run enable of every channel n whose data bit n is 1. Channels whose bit is 0 keep their enable.
- R3: A write to byte offset 0x08 clears the run enable of every channel n whose data bit n is 1. Channels whose bit is 0 keep their enable.
- R4: `ch_start[n]` pulses for exactly one cycle, in the cycle after a set write, only when channel n was not already enabled. A set write to a running channel gives no pulse.
- R5: A read of byte offset 0x0C returns the `ch_running` input, as sampled in the request cycle, in bits 3:0, with zeros above. A stopped channel therefore reads 1 until the channel block reports that it has halted.
- R6: A high `ch_period_start[n]` sets interrupt status bit n, and the bit stays set until the status word is read.
- R7: A read of byte offset 0x1C returns the interrupt status word as it stood before the read, and clears all bits together.
- R8: A period-start event that arrives in the same cycle as a read of offset 0x1C is not returned by that read. It stays set and appears in the next read.
- R9: Channel n's registers sit at byte address 0x200 + 0x20*n: mode at +0x00, duty at +0x04, period at +0x08. Writes store the full 32-bit word, which drives the channel's output field (bits 32n+31:32n) from the next cycle and reads back unchanged.
- R10: A write to window offset +0x10 stores the update word and pulses that channel's `ch_update_wr` bit for exactly one cycle. At most one strobe bit is high in any cycle.
- R11: `req_ready` is always 1. A read accepted in cycle t raises `rsp_valid` for cycle t+1 only, with its data on `rsp_rdata`. `rsp_rdata` is zero whenever `rsp_valid` is low.
- R12: Reads of any other address return 0, and writes to them change nothing. This covers offsets 0x00, 0x04 and 0x08 when read, addresses that are not word aligned, unused window offsets, and windows at or beyond 0x280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| ch_enable | output | 4 | Run enable per channel |
| ch_start | output | 4 | One-cycle pulse when a channel's enable rises |
| ch_running | input | 4 | Channel block reports that the generator is running |
| ch_period_start | input | 4 | Channel block reports the start of a new period |
| ch_mode | output | 128 | Mode words, channel n in bits 32n+31:32n |
| ch_duty | output | 128 | Duty words, packed per channel |
| ch_period | output | 128 | Period words, packed per channel |
| ch_update_val | output | 128 | Update words, packed per channel |
| ch_update_wr | output | 4 | One-cycle strobe when a channel's update word is written |

## Verification
A wrong enable bit shows at `ch_enable` in the cycle after the faulty write, and a missed or extra `ch_start` pulse shows in that same cycle. A lost or stale interrupt bit stays hidden until the next status read, where `rsp_rdata` goes wrong one cycle after the request. That is why the tests read the status word straight after each event pattern and again straight after each clearing read. A misrouted channel write shows on the packed register outputs in the next cycle. The reference model compares every output on every clock, so each of these faults is reported in the first cycle it becomes visible.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  // Global register byte offsets
  localparam int unsigned OFF_SET    = 4;
  localparam int unsigned OFF_CLR    = 8;
  localparam int unsigned OFF_RUN    = 12;
  localparam int unsigned OFF_EVT    = 28;
  // Channel windows
  localparam int unsigned WIN_BASE   = 512;
  localparam int unsigned WIN_SIZE   = 32;
  localparam int unsigned FOFF_MODE  = 0;
  localparam int unsigned FOFF_DUTY  = 4;
  localparam int unsigned FOFF_PER   = 8;
  localparam int unsigned FOFF_UPD   = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SET, SEL_CLR, SEL_RUN, SEL_EVT, SEL_CHAN
  } sel_e;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_MODE, FLD_DUTY, FLD_PER, FLD_UPD
  } fld_e;
endpackage

// File: rtl/pwmc_decode.sv
module pwmc_decode
  import pwmc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 10,
  parameter int CH_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output fld_e              fld,
  output logic [CH_W-1:0]   chan
);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(OFF_RUN);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFF_EVT);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + NCH * WIN_SIZE);

  // Windows are aligned to their size, so the channel index and field
  // offset are plain address slices.
  logic [4:0] off;

  always_comb begin
    off  = addr[4:0];
    chan = addr[5 +: CH_W];
    sel  = SEL_NONE;
    fld  = FLD_NONE;
    if (addr == A_SET)      sel = SEL_SET;
    else if (addr == A_CLR) sel = SEL_CLR;
    else if (addr == A_RUN) sel = SEL_RUN;
    else if (addr == A_EVT) sel = SEL_EVT;
    else if (addr >= WIN_LO && addr < WIN_HI) begin
      case (off)
        5'(FOFF_MODE): fld = FLD_MODE;
        5'(FOFF_DUTY): fld = FLD_DUTY;
        5'(FOFF_PER):  fld = FLD_PER;
        5'(FOFF_UPD):  fld = FLD_UPD;
        default:       fld = FLD_NONE;
      endcase
      if (fld != FLD_NONE) sel = SEL_CHAN;
    end
  end
endmodule

// File: rtl/pwmc_chan_regs.sv
module pwmc_chan_regs
  import pwmc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  fld_e          fld,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode,
  output logic [DW-1:0] duty,
  output logic [DW-1:0] period,
  output logic [DW-1:0] upd,
  output logic          upd_wr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      duty   <= '0;
      period <= '0;
      upd    <= '0;
      upd_wr <= 1'b0;
    end else begin
      upd_wr <= wr_en && (fld == FLD_UPD);
      if (wr_en) begin
        case (fld)
          FLD_MODE: mode   <= wdata;
          FLD_DUTY: duty   <= wdata;
          FLD_PER:  period <= wdata;
          FLD_UPD:  upd    <= wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwmc_global.sv
module pwmc_global #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_wr,
  input  logic           clr_wr,
  input  logic [NCH-1:0] wbits,
  input  logic           evt_rd,
  input  logic [NCH-1:0] period_start,
  output logic [NCH-1:0] enable,
  output logic [NCH-1:0] start,
  output logic [NCH-1:0] evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      start  <= '0;
      evt    <= '0;
    end else begin
      start <= '0;
      if (set_wr) begin
        enable <= enable | wbits;
        start  <= wbits & ~enable;
      end else if (clr_wr) begin
        enable <= enable & ~wbits;
      end
      // Read clears the old bits; a same-cycle event survives the clear.
      evt <= (evt_rd ? '0 : evt) | period_start;
    end
  end
endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH-1:0]    ch_start,
  input  logic [NCH-1:0]    ch_running,
  input  logic [NCH-1:0]    ch_period_start,
  output logic [NCH*DW-1:0] ch_mode,
  output logic [NCH*DW-1:0] ch_duty,
  output logic [NCH*DW-1:0] ch_period,
  output logic [NCH*DW-1:0] ch_update_val,
  output logic [NCH-1:0]    ch_update_wr
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            acc_rd, acc_wr;
  sel_e            sel;
  fld_e            fld;
  logic [CH_W-1:0] chan;
  logic [NCH-1:0]  evt_vec;
  logic [DW-1:0]   mode_a [NCH];
  logic [DW-1:0]   duty_a [NCH];
  logic [DW-1:0]   per_a  [NCH];
  logic [DW-1:0]   upd_a  [NCH];
  logic [DW-1:0]   rd_mux;

  assign req_ready = 1'b1;
  assign acc_rd    = req_valid && !req_write;
  assign acc_wr    = req_valid &&  req_write;

  pwmc_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .addr (req_addr),
    .sel  (sel),
    .fld  (fld),
    .chan (chan)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwmc_chan_regs #(.DW(DW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (acc_wr && (sel == SEL_CHAN) && (chan == CH_W'(i))),
      .fld    (fld),
      .wdata  (req_wdata),
      .mode   (mode_a[i]),
      .duty   (duty_a[i]),
      .period (per_a[i]),
      .upd    (upd_a[i]),
      .upd_wr (ch_update_wr[i])
    );
    assign ch_mode[i*DW +: DW]       = mode_a[i];
    assign ch_duty[i*DW +: DW]       = duty_a[i];
    assign ch_period[i*DW +: DW]     = per_a[i];
    assign ch_update_val[i*DW +: DW] = upd_a[i];
  end

  pwmc_global #(.NCH(NCH)) u_glb (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_wr       (acc_wr && (sel == SEL_SET)),
    .clr_wr       (acc_wr && (sel == SEL_CLR)),
    .wbits        (req_wdata[NCH-1:0]),
    .evt_rd       (acc_rd && (sel == SEL_EVT)),
    .period_start (ch_period_start),
    .enable       (ch_enable),
    .start        (ch_start),
    .evt          (evt_vec)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_RUN: rd_mux = {{(DW-NCH){1'b0}}, ch_running};
      SEL_EVT: rd_mux = {{(DW-NCH){1'b0}}, evt_vec};
      SEL_CHAN: begin
        case (fld)
          FLD_MODE: rd_mux = mode_a[chan];
          FLD_DUTY: rd_mux = duty_a[chan];
          FLD_PER:  rd_mux = per_a[chan];
          FLD_UPD:  rd_mux = upd_a[chan];
          default:  rd_mux = '0;
        endcase
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_rd;
      rsp_rdata <= acc_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pwmc_checker.sv
module pwmc_checker
  import pwmc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [NCH-1:0]    ch_enable,
  input logic [NCH-1:0]    ch_start,
  input logic [NCH-1:0]    ch_update_wr,
  input logic [NCH-1:0]    ch_period_start,
  input logic [NCH-1:0]    evt_vec
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);

  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r11_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r4_start_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start & ~(ch_enable & ~$past(ch_enable))) == '0);

  a_r2_rise_needs_set_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_enable & ~$past(ch_enable)) != '0) |->
      $past(req_valid && req_write && req_addr == A_SET));

  a_r3_fall_needs_clr_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ch_enable & $past(ch_enable)) != '0) |->
      $past(req_valid && req_write && req_addr == A_CLR));

  a_r6_event_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_period_start != '0) |=>
      ((evt_vec & $past(ch_period_start)) == $past(ch_period_start)));

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_update_wr));
endmodule

bind pwmc_top pwmc_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .req_addr        (req_addr),
  .rsp_valid       (rsp_valid),
  .ch_enable       (ch_enable),
  .ch_start        (ch_start),
  .ch_update_wr    (ch_update_wr),
  .ch_period_start (ch_period_start),
  .evt_vec         (evt_vec)
);

// File: tb/tb_pwmc_top.sv
module tb_pwmc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]   req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   ch_running = '0, ch_period_start = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [3:0]   ch_enable, ch_start, ch_update_wr;
  logic [127:0] ch_mode, ch_duty, ch_period, ch_update_val;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pwmc_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ch_enable(ch_enable),
    .ch_start(ch_start), .ch_running(ch_running),
    .ch_period_start(ch_period_start), .ch_mode(ch_mode), .ch_duty(ch_duty),
    .ch_period(ch_period), .ch_update_val(ch_update_val),
    .ch_update_wr(ch_update_wr)
  );

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_mode[4], m_duty[4], m_per[4], m_upd[4];
  logic [3:0]  m_en, m_start, m_updwr, m_evt;
  logic        m_rv;
  logic [31:0] m_rd;

  function automatic logic [31:0] ref_read(logic [9:0] a);
    int c;
    if (a == 10'h00C) return {28'd0, ch_running};
    if (a == 10'h01C) return {28'd0, m_evt};
    if (a >= 10'h200 && a < 10'h280) begin
      c = (int'(a) - 512) / 32;
      case (int'(a) % 32)
        0:  return m_mode[c];
        4:  return m_duty[c];
        8:  return m_per[c];
        16: return m_upd[c];
        default: return 32'd0;
      endcase
    end
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_mode[i] = 0; m_duty[i] = 0; m_per[i] = 0; m_upd[i] = 0;
      end
      m_en = 0; m_start = 0; m_updwr = 0; m_evt = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = req_valid && !req_write;
      m_rd = m_rv ? ref_read(req_addr) : 32'd0;
      if (m_rv && req_addr == 10'h01C) m_evt = ch_period_start;
      else m_evt = m_evt | ch_period_start;
      m_start = 0; m_updwr = 0;
      if (req_valid && req_write) begin
        if (req_addr == 10'h004) begin
          m_start = req_wdata[3:0] & ~m_en;
          m_en = m_en | req_wdata[3:0];
        end else if (req_addr == 10'h008) begin
          m_en = m_en & ~req_wdata[3:0];
        end else if (req_addr >= 10'h200 && req_addr < 10'h280) begin
          int c;
          c = (int'(req_addr) - 512) / 32;
          case (int'(req_addr) % 32)
            0:  m_mode[c] = req_wdata;
            4:  m_duty[c] = req_wdata;
            8:  m_per[c]  = req_wdata;
            16: begin m_upd[c] = req_wdata; m_updwr[c] = 1'b1; end
            default: ;
          endcase
        end
      end
    end
    #5;
    check("R2 R3", "ch_enable", 128'(ch_enable), 128'(m_en));
    check("R4", "ch_start", 128'(ch_start), 128'(m_start));
    check("R10", "ch_update_wr", 128'(ch_update_wr), 128'(m_updwr));
    check("R11", "rsp_valid", 128'(rsp_valid), 128'(m_rv));
    check("R11", "req_ready", 128'(req_ready), 128'(1'b1));
    check("R7 R12", "rsp_rdata", 128'(rsp_rdata), 128'(m_rd));
    check("R9", "ch_mode", ch_mode, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
    check("R9", "ch_duty", ch_duty, {m_duty[3], m_duty[2], m_duty[1], m_duty[0]});
    check("R9", "ch_period", ch_period, {m_per[3], m_per[2], m_per[1], m_per[0]});
    check("R10", "ch_update_val", ch_update_val, {m_upd[3], m_upd[2], m_upd[1], m_upd[0]});
  end

  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset enables", 128'(ch_enable), 128'(0));
    check("R1", "reset mode", ch_mode, 128'(0));
    rst_n = 1;
    bus_rd(10'h01C, d); check("R1", "reset event word", 128'(d), 128'(0));

    // R2/R4: set write starts channels 0 and 2
    bus_wr(10'h004, 32'h5);
    check("R2", "enable after set", 128'(ch_enable), 128'(4'h5));
    // R4: channel 0 already running gets no pulse, channel 1 does
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 10'h004; req_wdata = 32'h3;
    @(negedge clk); req_valid = 0; req_write = 0;
    check("R4", "start only new channel", 128'(ch_start), 128'(4'h2));
    @(negedge clk);
    check("R4", "start is one cycle", 128'(ch_start), 128'(0));

    // R3: clear channel 0, zeros elsewhere do nothing
    bus_wr(10'h008, 32'h1);
    check("R3", "enable after clear", 128'(ch_enable), 128'(4'h6));

    // R5: running status follows the channel block
    ch_running = 4'h7;
    bus_rd(10'h00C, d); check("R5", "status while stopping", 128'(d), 128'(7));
    ch_running = 4'h6;
    bus_rd(10'h00C, d); check("R5", "status after stop", 128'(d), 128'(6));

    // R6/R7: sticky events, read returns and clears
    @(negedge clk); ch_period_start = 4'h3;
    @(negedge clk); ch_period_start = 4'h0;
    repeat (2) @(negedge clk);
    bus_rd(10'h01C, d); check("R6", "sticky events", 128'(d), 128'(3));
    bus_rd(10'h01C, d); check("R7", "cleared by read", 128'(d), 128'(0));

    // R8: event in the read cycle survives
    @(negedge clk); ch_period_start = 4'h1;
    @(negedge clk); ch_period_start = 4'h8; req_valid = 1; req_write = 0; req_addr = 10'h01C;
    @(negedge clk); ch_period_start = 4'h0; req_valid = 0;
    check("R8", "read excludes same-cycle event", 128'(rsp_rdata), 128'(1));
    bus_rd(10'h01C, d); check("R8", "same-cycle event kept", 128'(d), 128'(8));

    // R9: window writes and read-back
    for (int c = 0; c < 4; c++) begin
      bus_wr(10'(512 + 32*c), 32'hA000_0000 + c);
      bus_wr(10'(512 + 32*c + 4), 32'h0000_1100 + c);
      bus_wr(10'(512 + 32*c + 8), 32'h0002_0000 + c);
    end
    for (int c = 0; c < 4; c++) begin
      bus_rd(10'(512 + 32*c + 4), d);
      check("R9", "duty readback", 128'(d), 128'(32'h0000_1100 + c));
    end
    check("R9", "period field ch3", 128'(ch_period[127:96]), 128'(32'h0002_0003));

    // R10: update word and strobe
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 10'h250; req_wdata = 32'hCAFE;
    @(negedge clk); req_valid = 0; req_write = 0;
    check("R10", "update strobe ch2", 128'(ch_update_wr), 128'(4'h4));
    check("R10", "update value ch2", 128'(ch_update_val[95:64]), 128'(32'hCAFE));

    // R12: unmapped accesses
    bus_rd(10'h000, d); check("R12", "offset 0", 128'(d), 128'(0));
    bus_rd(10'h004, d); check("R12", "set reg read", 128'(d), 128'(0));
    bus_rd(10'h202, d); check("R12", "unaligned", 128'(d), 128'(0));
    bus_rd(10'h214, d); check("R12", "unused window field", 128'(d), 128'(0));
    bus_wr(10'h280, 32'hFFFF);
    bus_rd(10'h280, d); check("R12", "beyond last window", 128'(d), 128'(0));
    bus_wr(10'h006, 32'hF);
    check("R12", "unaligned set ignored", 128'(ch_enable), 128'(4'h6));

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule